// File: doc/BRIEF.md
# Write-Status Read Path

This block is the read side of a byte-wide nonvolatile memory. An access counts as a qualified read while chip enable and output enable are both low and write enable is high. During such an access the block registers one byte and raises an output-enable flag that models the pin drivers. Outside a qualified read the flag is low and the registered byte is zero, which stands for high impedance. The array itself sits outside the block. The block passes the address through to the array and takes the array's byte back on a combinational return path.

While the page write controller reports busy, every read is a status poll, from the first cycle of the write to the last. A poll does not return array contents. The top bit comes back as the inverse of the top bit of the last byte written. The bit below it comes from a toggle register that inverts after each poll access. The low six bits come from the last written byte. When busy clears, reads again return true array data and the toggle bit stops moving.

A small sequencer with three states drives the block:

- **RS_IDLE**: no access.
- **RS_ARRAY**: a read of true data.
- **RS_POLL**: a read while busy.

The transitions are evaluated on each clock edge from the qualified strobe and busy:

- **T_START_ARRAY** (IDLE to ARRAY): a qualified read with busy low.
- **T_START_POLL** (IDLE to POLL): a qualified read with busy high.
- **T_BUSY_ON** (ARRAY to POLL): busy rises during an access.
- **T_BUSY_OFF** (POLL to ARRAY): busy falls during an access.
- **T_HOLD** (ARRAY or POLL to itself): the access continues with busy unchanged.
- **T_END** (ARRAY or POLL to IDLE): the strobe drops.

The toggle register advances only on a T_END taken from RS_POLL.

Top module: `wsr_read_path`

## Requirements
- R1: A read qualifies when ce_n=0, oe_n=0 and we_n=1. On the clock edge where a read qualifies, dout_oe goes to 1, so it reads 1 from the following cycle. It stays 1 for as long as the read stays qualified.
- R2: On any edge where ce_n=1, oe_n=1 or we_n=0, dout_oe goes to 0 and dout goes to 0 (high impedance).
- R3: A qualified read sampled with busy=1 registers dout[7] as the inverse of last_wr_data[7].
- R4: A qualified read sampled with busy=1 registers dout[5:0] equal to last_wr_data[5:0].
- R5: During a poll, dout[6] shows the toggle register. The register is 0 after reset and holds constant within one access. It inverts once when an access that was in the poll state at its last qualified edge ends.
- R6: A qualified read sampled with busy=0 registers dout equal to arr_data, with one cycle of latency. arr_addr follows addr combinationally.
- R7: While rst_n=0, dout=0 and dout_oe=0.
- R8: An access that ends while not in the poll state leaves the toggle register unchanged, so bit 6 stops toggling once busy clears.
- R9: If busy changes in the middle of an access, the byte registered on the next edge already follows the new busy value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 15 | Read address |
| busy | input | 1 | Page write in progress |
| last_wr_data | input | 8 | Last byte written by the write controller |
| arr_addr | output | 15 | Address presented to the array |
| arr_data | input | 8 | Byte returned by the array |
| dout | output | 8 | Registered output byte, 0 when not driven |
| dout_oe | output | 1 | Output drivers enabled |

## Verification
The bench targets the following corner cases, each paired with the fault it exposes:

- **Back-to-back polls** separated by a single idle cycle. A toggle that advanced per clock rather than per access would change bit 6 inside a long access. A toggle that never advanced would return the same bit 6 twice in a row.
- **Reads right after busy clears.** These confirm that bit 6 freezes and that all eight bits come from the array. A design that kept toggling, or kept inverting bit 7, would be caught here.
- **Busy changing in the middle of an access.** This exposes a sequencer that latches the mode only at the start of an access.
- **Each of the three disqualifying strobe levels**, in particular we_n low with the other two low. This exposes a qualifier that ignores write enable.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_ARRAY = 2'd1,
        RS_POLL  = 2'd2
    } rd_state_t;
endpackage

// File: rtl/wsr_seq.sv
module wsr_seq
    import wsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rd_qual,
    input  logic      busy,
    output rd_state_t state,
    output logic      drive,
    output logic      poll_end
);
    rd_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RS_IDLE:  state_nx = rd_qual ? (busy ? RS_POLL : RS_ARRAY) : RS_IDLE;
            RS_ARRAY: state_nx = rd_qual ? (busy ? RS_POLL : RS_ARRAY) : RS_IDLE;
            RS_POLL:  state_nx = rd_qual ? (busy ? RS_POLL : RS_ARRAY) : RS_IDLE;
            default:  state_nx = RS_IDLE;
        endcase
    end

    always_comb begin
        drive    = 1'b0;
        poll_end = 1'b0;
        unique case (state)
            RS_IDLE:  drive = 1'b0;
            RS_ARRAY: drive = 1'b1;
            RS_POLL:  begin
                drive    = 1'b1;
                poll_end = !rd_qual;
            end
            default:  drive = 1'b0;
        endcase
    end

    AST_OE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_qual |=> drive);                                   // R1
    AST_OE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_qual |=> !drive);                                 // R2
    AST_POLL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_qual && busy) |=> (state == RS_POLL));            // R9
endmodule

// File: rtl/wsr_toggle.sv
module wsr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic tog
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tog <= 1'b0;
        else if (advance) tog <= ~tog;
    end

    AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (tog != $past(tog)));                     // R5
    AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(tog));                           // R8
endmodule

// File: rtl/wsr_outreg.sv
module wsr_outreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_qual,
    input  logic              busy,
    input  logic              tog,
    input  logic [DATA_W-1:0] last_wr_data,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dout
);
    localparam int STAT_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] next_word;

    always_comb begin
        status_word           = last_wr_data;
        status_word[STAT_BIT] = ~last_wr_data[STAT_BIT];
        status_word[TOG_BIT]  = tog;
    end

    always_comb begin
        if (!rd_qual)  next_word = '0;
        else if (busy) next_word = status_word;
        else           next_word = arr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout <= '0;
        else        dout <= next_word;
    end

    AST_STAT_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_qual && busy) |=> (dout[STAT_BIT] == ~$past(last_wr_data[STAT_BIT]))); // R3
    AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_qual && busy) |=> (dout[TOG_BIT-1:0] == $past(last_wr_data[TOG_BIT-1:0]))); // R4
    AST_TRUE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_qual && !busy) |=> (dout == $past(arr_data)));    // R6
    AST_HIZ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_qual |=> (dout == '0));                           // R2
endmodule

// File: rtl/wsr_read_path.sv
module wsr_read_path #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    input  logic [DATA_W-1:0] last_wr_data,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    import wsr_pkg::*;

    logic      rd_qual;
    logic      poll_end;
    logic      tog;
    rd_state_t state;

    assign rd_qual  = !ce_n && !oe_n && we_n;
    assign arr_addr = addr;

    wsr_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_qual  (rd_qual),
        .busy     (busy),
        .state    (state),
        .drive    (dout_oe),
        .poll_end (poll_end)
    );

    wsr_toggle u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (poll_end),
        .tog     (tog)
    );

    wsr_outreg #(.DATA_W(DATA_W)) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_qual      (rd_qual),
        .busy         (busy),
        .tog          (tog),
        .last_wr_data (last_wr_data),
        .arr_data     (arr_data),
        .dout         (dout)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!dout_oe && dout == '0));                 // R7
    AST_DRIVE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (state != RS_IDLE));                      // R1
endmodule

// File: tb/wsr_read_path_bench.sv
module wsr_read_path_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  lw = '0;
    logic [14:0] arr_addr;
    logic [7:0]  arr_data, dout;
    logic        dout_oe;
    int          checks = 0, failures = 0;
    logic        m_tog = 1'b0, m_poll = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [7:0] arrf(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    assign arr_data = arrf(arr_addr);

    wsr_read_path u_wsr_read_path (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .busy(busy), .last_wr_data(lw), .arr_addr(arr_addr),
        .arr_data(arr_data), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h exp %h", req, got, exp);
        end
    endtask

    task automatic step(input logic c, input logic o, input logic w, input logic b,
                        input logic [14:0] a, input logic [7:0] d, input string req);
        logic       q;
        logic [7:0] e;
        ce_n = c; oe_n = o; we_n = w; busy = b; addr = a; lw = d;
        #1;
        chk("R6 arr_addr", {1'b0, arr_addr[6:0]}, {1'b0, a[6:0]});
        @(posedge clk);
        q = !c && !o && w;
        if (!q)     e = 8'h00;
        else if (b) e = {~d[7], m_tog, d[5:0]};
        else        e = arrf(a);
        if (!q && m_poll) m_tog = ~m_tog;
        m_poll = q && b;
        @(negedge clk);
        chk({req, " oe"}, {7'd0, dout_oe}, {7'd0, q});
        chk({req, " dout"}, dout, e);
    endtask

    initial begin
        #1600000;
        failures++;
        $display("FAIL watchdog: got timeout exp done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R7 oe", {7'd0, dout_oe}, 8'd0);
        chk("R7 dout", dout, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 each disqualifying strobe level
        step(1, 0, 1, 0, 15'h0123, 8'h00, "R2 ce");
        step(0, 1, 1, 0, 15'h0123, 8'h00, "R2 oe");
        step(0, 0, 0, 0, 15'h0123, 8'h00, "R2 we");
        // R1 R6 array reads, address changing within an access
        step(0, 0, 1, 0, 15'h7FFF, 8'h00, "R6 a");
        step(0, 0, 1, 0, 15'h0040, 8'h00, "R1 hold");
        step(1, 1, 1, 0, 15'h0040, 8'h00, "R2 end");
        // R3 R4 R5 polls, toggle constant within an access
        for (int i = 0; i < 4; i++) begin
            step(0, 0, 1, 1, 15'h0011, 8'hC5, "R5 poll");
            step(0, 0, 1, 1, 15'h0011, 8'hC5, "R5 same");
            step(1, 0, 1, 1, 15'h0011, 8'hC5, "R5 gap");
        end
        step(0, 0, 1, 1, 15'h0011, 8'h3A, "R3 zero msb");
        step(1, 1, 1, 1, 15'h0011, 8'h3A, "R4 gap");
        // R8 busy clears: no further toggling
        for (int i = 0; i < 3; i++) begin
            step(0, 0, 1, 0, 15'h0200, 8'h3A, "R8 read");
            step(1, 1, 1, 0, 15'h0200, 8'h3A, "R8 gap");
        end
        step(0, 0, 1, 1, 15'h0200, 8'h3A, "R8 poll again");
        step(1, 1, 1, 1, 15'h0200, 8'h3A, "R8 gap");
        // R9 busy changes mid access
        step(0, 0, 1, 0, 15'h1234, 8'h81, "R9 array");
        step(0, 0, 1, 1, 15'h1234, 8'h81, "R9 busy on");
        step(0, 0, 1, 0, 15'h1234, 8'h81, "R9 busy off");
        step(1, 1, 1, 0, 15'h1234, 8'h81, "R9 end");
        step(0, 0, 1, 1, 15'h1234, 8'h81, "R9 poll");
        step(1, 1, 1, 1, 15'h1234, 8'h81, "R9 end2");
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic rc, ro, rw, rb;
            rc = ($urandom % 4) == 0;
            ro = ($urandom % 4) == 0;
            rw = ($urandom % 5) != 0;
            rb = $urandom % 2;
            step(rc, ro, rw, rb, 15'($urandom), 8'($urandom), "R1 R3 R5 rand");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule